// File: doc/BRIEF.md
# Boundary-Scan Test Port with Pad Chain

This block is a JTAG test access port for a group of bidirectional I/O pads. A 16-state TAP controller is clocked by TCK and steered by TMS. It selects one of three data registers through a 4-bit instruction register: a 32-bit device identity, a one-bit bypass, and a boundary-scan chain. The chain sits between the core's output, output-enable and input vectors and the matching pad-side vectors.

Each I/O has three scan cells. The input cell watches the pad input and can force the core input. The output cell watches the pad output and can force it. The enable cell watches the pad output-enable and can force it. Each cell has a shift stage, which captures and shifts, and an update stage, which holds the value that is driven.

Under SAMPLE the scan chain only observes, and the functional paths stay connected. Under EXTEST the update stage takes over the pad outputs, the pad output-enables and the core inputs. The instruction and identity registers shift least-significant bit first. The boundary chain shifts most-significant bit first. TDO changes on the falling edge of TCK.

Top module: `jtag_bscan_top`

## Requirements
- R1: The controller implements the 16-state TAP state machine and advances on rising TCK according to TMS, including the Pause-DR and Exit2-DR loop back into Shift-DR. Five rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: Asserting trst_n low, or passing through Test-Logic-Reset, selects IDCODE (the instruction becomes IDCODE at the rising TCK taken in that state) and returns every I/O to functional mode. After reset tdo_en is low and tdo is high.
- R3: The instruction register is 4 bits wide and shifts from TDI least-significant bit first. Capture-IR loads 4'b0001. The codes are EXTEST = 4'h0, IDCODE = 4'h1, SAMPLE = 4'h2 and BYPASS = 4'hF. Any other code acts as BYPASS.
- R4: Under IDCODE, Capture-DR loads the 32-bit ID_VALUE parameter, which then leaves on TDO least-significant bit first.
- R5: Under BYPASS or an unassigned code, a one-bit register is captured to 0, and each TDI bit appears on TDO one shift later.
- R6: The boundary chain has 3*NUM_IO bits. It shifts in from TDI most-significant bit first and presents its most-significant bit on TDO first. For I/O i, bit 3i is the input cell, bit 3i+1 is the output cell and bit 3i+2 is the enable cell.
- R7: Under SAMPLE or EXTEST, Capture-DR loads pad_in into the input cells, the current pad_out into the output cells and the current pad_oe into the enable cells.
- R8: Under SAMPLE (and every instruction other than EXTEST), pad_out = core_out, pad_oe = core_oe and core_in = pad_in.
- R9: Under EXTEST, pad_out, pad_oe and core_in take the update stage of the output, enable and input cells. The update stage is 0 after reset.
- R10: The update stage loads from the shift stage only in Update-DR while the chain is selected, so the driven values stay still during Shift-DR and Pause-DR.
- R11: TDO and tdo_en change only on falling TCK. tdo_en is high only while in Shift-IR or Shift-DR. Otherwise tdo is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| core_out | input | NUM_IO | Output data from the core |
| core_oe | input | NUM_IO | Output enables from the core |
| core_in | output | NUM_IO | Input data to the core |
| pad_in | input | NUM_IO | Input data from the pads |
| pad_out | output | NUM_IO | Output data to the pads |
| pad_oe | output | NUM_IO | Output enables to the pads |

## Verification
The bench targets the opposite bit orders of the instruction and boundary registers. A design that shifted the chain LSB first would return a reversed capture, and under EXTEST would drive a mirrored pattern onto the pads. Under EXTEST the bench captures the pins while the update stage already drives them, so a capture taken from the core side instead of the pad side shows up as a wrong value. The bench also splits one boundary shift across a Pause-DR loop, leaves Shift-DR through five TMS-high clocks, and watches the pads during every shift. A design with a transparent update stage would ripple the pads during shifting. A design that advanced TDO on the rising edge would show TDO changing right after that edge. A design that kept EXTEST after reset would leave the pads detached from the core.

// File: rtl/jtag_bs_pkg.sv
package jtag_bs_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

  typedef enum logic [3:0] {
    TS_RESET,
    TS_IDLE,
    TS_SEL_DR,
    TS_CAP_DR,
    TS_SH_DR,
    TS_EX1_DR,
    TS_PAU_DR,
    TS_EX2_DR,
    TS_UPD_DR,
    TS_SEL_IR,
    TS_CAP_IR,
    TS_SH_IR,
    TS_EX1_IR,
    TS_PAU_IR,
    TS_EX2_IR,
    TS_UPD_IR
  } tap_state_e;

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_bs_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  state_d = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  state_d = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
      default:   state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= TS_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // Run length of consecutive TMS-high clocks, saturating at five.
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              tms_run <= 3'd0;
    else if (!tms)           tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run == 3'd5) |-> (state_q == TS_RESET));

  assert_reset_exit_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (state_q == TS_RESET && !tms) |=> (state_q == TS_IDLE));

endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain #(
  parameter int NUM_IO = 4
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic                upd_en,
  input  logic                tdi,
  input  logic [3*NUM_IO-1:0] cap_vec,
  output logic                so,
  output logic [3*NUM_IO-1:0] upd_vec
);

  localparam int CH = 3 * NUM_IO;

  logic [CH-1:0] sh_q, sh_d, up_q, up_d;

  // Bit 0 is fed from TDI, so the first bit shifted in ends up at the top.
  for (genvar b = 0; b < CH; b++) begin : g_cell
    logic src;
    if (b == 0) begin : g_head
      assign src = tdi;
    end else begin : g_link
      assign src = sh_q[b-1];
    end
    always_comb begin
      if (cap_en)        sh_d[b] = cap_vec[b];
      else if (shift_en) sh_d[b] = src;
      else               sh_d[b] = sh_q[b];
    end
  end

  always_comb up_d = upd_en ? sh_q : up_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      up_q <= '0;
    end else begin
      sh_q <= sh_d;
      up_q <= up_d;
    end
  end

  assign so      = sh_q[CH-1];
  assign upd_vec = up_q;

  assert_upd_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_en |=> $stable(up_q));

  assert_cap_load_R7: assert property (@(posedge tck) disable iff (!rst_n)
    cap_en |=> (sh_q == $past(cap_vec)));

endmodule

// File: rtl/jtag_bscan_top.sv
module jtag_bscan_top
  import jtag_bs_pkg::*;
#(
  parameter int          NUM_IO   = 4,
  parameter logic [31:0] ID_VALUE = 32'h4B1D_7A03
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [NUM_IO-1:0] core_out,
  input  logic [NUM_IO-1:0] core_oe,
  output logic [NUM_IO-1:0] core_in,
  input  logic [NUM_IO-1:0] pad_in,
  output logic [NUM_IO-1:0] pad_out,
  output logic [NUM_IO-1:0] pad_oe
);

  localparam int CH = 3 * NUM_IO;

  // Reset: asserted at once, released on a TCK edge.
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  tap_state_e state;

  jtag_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  // Instruction register: shift stage LSB first, plus the active instruction.
  logic [IR_W-1:0] ir_sr, ir_sr_d, ir_q, ir_q_d;

  always_comb begin
    ir_sr_d = ir_sr;
    if (state == TS_CAP_IR)     ir_sr_d = {{(IR_W-2){1'b0}}, 2'b01};
    else if (state == TS_SH_IR) ir_sr_d = {tdi, ir_sr[IR_W-1:1]};
    ir_q_d = ir_q;
    if (state == TS_RESET)       ir_q_d = OP_IDCODE;
    else if (state == TS_UPD_IR) ir_q_d = ir_sr;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= '0;
      ir_q  <= OP_IDCODE;
    end else begin
      ir_sr <= ir_sr_d;
      ir_q  <= ir_q_d;
    end
  end

  logic sel_ext, sel_smp, sel_id, sel_bs;
  assign sel_ext = (ir_q == OP_EXTEST);
  assign sel_smp = (ir_q == OP_SAMPLE);
  assign sel_id  = (ir_q == OP_IDCODE);
  assign sel_bs  = sel_ext | sel_smp;

  // Identity and bypass registers.
  logic [ID_W-1:0] id_sr, id_sr_d;
  logic            byp_q, byp_d;

  always_comb begin
    id_sr_d = id_sr;
    byp_d   = byp_q;
    if (state == TS_CAP_DR) begin
      if (sel_id) id_sr_d = ID_VALUE;
      byp_d = 1'b0;
    end else if (state == TS_SH_DR) begin
      if (sel_id) id_sr_d = {tdi, id_sr[ID_W-1:1]};
      byp_d = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      id_sr <= id_sr_d;
      byp_q <= byp_d;
    end
  end

  // Boundary chain.
  logic [CH-1:0] cap_vec, upd_vec;
  logic          bs_so;

  for (genvar i = 0; i < NUM_IO; i++) begin : g_io
    assign cap_vec[3*i]   = pad_in[i];
    assign cap_vec[3*i+1] = pad_out[i];
    assign cap_vec[3*i+2] = pad_oe[i];
    assign core_in[i] = sel_ext ? upd_vec[3*i]   : pad_in[i];
    assign pad_out[i] = sel_ext ? upd_vec[3*i+1] : core_out[i];
    assign pad_oe[i]  = sel_ext ? upd_vec[3*i+2] : core_oe[i];
  end

  jtag_bscan_chain #(.NUM_IO(NUM_IO)) u_chain (
    .tck      (tck),
    .rst_n    (rst_n),
    .cap_en   (state == TS_CAP_DR && sel_bs),
    .shift_en (state == TS_SH_DR && sel_bs),
    .upd_en   (state == TS_UPD_DR && sel_bs),
    .tdi      (tdi),
    .cap_vec  (cap_vec),
    .so       (bs_so),
    .upd_vec  (upd_vec)
  );

  // TDO path, retimed to falling TCK.
  logic tdo_bit, shifting, tdo_q, tdo_en_q;

  always_comb begin
    tdo_bit  = 1'b1;
    shifting = 1'b0;
    if (state == TS_SH_IR) begin
      tdo_bit  = ir_sr[0];
      shifting = 1'b1;
    end else if (state == TS_SH_DR) begin
      shifting = 1'b1;
      if (sel_bs)      tdo_bit = bs_so;
      else if (sel_id) tdo_bit = id_sr[0];
      else             tdo_bit = byp_q;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q    <= 1'b1;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_bit;
      tdo_en_q <= shifting;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_en = tdo_en_q;

  assert_tdo_en_shift_R11: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == TS_SH_DR || state == TS_SH_IR));

  assert_tdo_idle_high_R11: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_en |-> tdo);

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> (ir_q == OP_IDCODE));

endmodule

// File: tb/jtag_bscan_top_bench.sv
module jtag_bscan_top_bench;

  localparam int          NIO = 4;
  localparam int          CH  = 3 * NIO;
  localparam logic [31:0] IDV = 32'h4B1D_7A03;

  typedef struct packed {
    logic [3:0]    ir;
    logic [3:0]    co;
    logic [3:0]    coe;
    logic [3:0]    pi;
    logic [CH-1:0] data;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{4'h2, 4'h0, 4'h0, 4'h0, 12'hFFF},
    '{4'h0, 4'h0, 4'h0, 4'h0, 12'hFFF},
    '{4'h0, 4'hF, 4'hF, 4'hF, 12'h000},
    '{4'h2, 4'hF, 4'hF, 4'hF, 12'h000},
    '{4'h0, 4'hA, 4'h5, 4'h3, 12'h5A3},
    '{4'h2, 4'h6, 4'h9, 4'hC, 12'h9C6}
  };

  logic tck, trst_n, tms, tdi, tdo, tdo_en;
  logic [NIO-1:0] core_out, core_oe, core_in, pad_in, pad_out, pad_oe;

  jtag_bscan_top #(.NUM_IO(NIO), .ID_VALUE(IDV)) u_jtag_bscan_top (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  initial tck = 1'b0;
  always #5 tck = ~tck;

  int   n_chk = 0, n_fail = 0;
  int   en_bad = 0, edge_bad = 0, hold_bad = 0;
  logic en_seen;
  logic [CH-1:0] upd_m;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One TCK: drive after the falling edge, sample TDO there, let the rising edge act.
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    o = tdo;
    en_seen = tdo_en;
    @(posedge tck);
    #1;
    if (tdo !== o) edge_bad++;
  endtask

  // From Run-Test/Idle: full scan of n bits, bit k of sin sent k-th; back to Run-Test/Idle.
  task automatic shift_seq(input logic is_ir, input int n, input logic [63:0] sin,
                           output logic [63:0] sout);
    logic o;
    logic [NIO-1:0] snap;
    sout = '0;
    step(1'b1, 1'b0, o);
    if (is_ir) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    snap = pad_out;
    for (int k = 0; k < n; k++) begin
      step(k == n-1, sin[k], o);
      sout[k] = o;
      if (!en_seen) en_bad++;
      if (pad_out !== snap) hold_bad++;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  function automatic logic [63:0] rev(input logic [63:0] v);
    logic [63:0] r = '0;
    for (int k = 0; k < CH; k++) r[CH-1-k] = v[k];
    return r;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] so, cexp;
    logic [NIO-1:0] epo, eoe, eci;
    logic o, ext;
    logic [CH-1:0] pd;

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    core_out = 4'h5; core_oe = 4'h3; pad_in = 4'h9;
    upd_m = '0;
    repeat (3) @(posedge tck);
    @(negedge tck); trst_n = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    chk("R2 reset tdo_en", tdo_en, 1'b0);
    chk("R2 reset tdo", tdo, 1'b1);
    chk("R2 reset pad_out", pad_out, core_out);
    chk("R2 reset core_in", core_in, pad_in);

    step(1'b0, 1'b0, o);
    shift_seq(1'b0, 32, '0, so);
    chk("R4 idcode after reset", so[31:0], IDV);

    shift_seq(1'b1, 4, 64'h2, so);
    chk("R3 ir capture pattern", so[3:0], 4'b0001);
    chk("R11 idle tdo_en", tdo_en, 1'b0);
    chk("R11 idle tdo high", tdo, 1'b1);

    // Vector table: R6 R7 R8 R9
    foreach (TBL[t]) begin
      core_out = TBL[t].co; core_oe = TBL[t].coe; pad_in = TBL[t].pi;
      shift_seq(1'b1, 4, {60'd0, TBL[t].ir}, so);
      ext = (TBL[t].ir == 4'h0);
      cexp = '0;
      for (int i = 0; i < NIO; i++) begin
        cexp[3*i]   = TBL[t].pi[i];
        cexp[3*i+1] = ext ? upd_m[3*i+1] : TBL[t].co[i];
        cexp[3*i+2] = ext ? upd_m[3*i+2] : TBL[t].coe[i];
      end
      shift_seq(1'b0, CH, rev({52'd0, TBL[t].data}), so);
      chk($sformatf("R6 R7 capture row %0d", t), rev(so), cexp);
      upd_m = TBL[t].data;
      for (int i = 0; i < NIO; i++) begin
        eci[i] = ext ? upd_m[3*i]   : TBL[t].pi[i];
        epo[i] = ext ? upd_m[3*i+1] : TBL[t].co[i];
        eoe[i] = ext ? upd_m[3*i+2] : TBL[t].coe[i];
      end
      chk($sformatf("%s pad_out row %0d", ext ? "R9" : "R8", t), pad_out, epo);
      chk($sformatf("%s pad_oe row %0d",  ext ? "R9" : "R8", t), pad_oe, eoe);
      chk($sformatf("%s core_in row %0d", ext ? "R9" : "R8", t), core_in, eci);
    end

    // R5 bypass and an unassigned code.
    shift_seq(1'b1, 4, 64'hF, so);
    shift_seq(1'b0, 8, 64'hB2, so);
    chk("R5 bypass delay", so[7:0], 8'h64);
    shift_seq(1'b1, 4, 64'h7, so);
    shift_seq(1'b0, 8, 64'h5D, so);
    chk("R3 R5 unassigned code bypass", so[7:0], 8'hBA);

    // R1 R10: EXTEST shift split by a Pause-DR loop.
    shift_seq(1'b1, 4, 64'h0, so);
    pd = 12'hC3A;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int k = 0; k < 6; k++) step(k == 5, pd[CH-1-k], o);
    step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    chk("R10 pads still in Pause-DR", pad_out, {upd_m[10], upd_m[7], upd_m[4], upd_m[1]});
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    for (int k = 6; k < CH; k++) step(k == CH-1, pd[CH-1-k], o);
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    chk("R1 R9 pause path pad_out", pad_out, {pd[10], pd[7], pd[4], pd[1]});
    chk("R1 R9 pause path pad_oe", pad_oe, {pd[11], pd[8], pd[5], pd[2]});
    chk("R1 R9 pause path core_in", core_in, {pd[9], pd[6], pd[3], pd[0]});

    // R1 R2: five TMS-high clocks out of Shift-DR reach Test-Logic-Reset.
    core_out = 4'h3; core_oe = 4'hC; pad_in = 4'h6;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    repeat (5) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk("R1 R2 tms reset pad_out", pad_out, core_out);
    chk("R1 R2 tms reset pad_oe", pad_oe, core_oe);
    chk("R1 R2 tms reset core_in", core_in, pad_in);
    shift_seq(1'b0, 32, '0, so);
    chk("R2 R4 idcode after tms reset", so[31:0], IDV);

    chk("R11 tdo_en during shifts", en_bad, 0);
    chk("R11 tdo steady after rising edge", edge_bad, 0);
    chk("R10 pads steady during Shift-DR", hold_bad, 0);

    finish_run();
  end

endmodule